// File: doc/BRIEF.md
# System Control Port with CPU Wait-State Generator

This block sits on the I/O side of an 8-bit processor bus. Four consecutive I/O port addresses each take a two-bit value from the data bus. The two bits D1 and D0 are decoded per port. The decoded values drive four diagnostic lamps, the enable for the RS-422 serial channel, the automatic-wait enable and the main memory bank select. Every one of these outputs is held in a register.

The same block produces the processor's active-low wait line. The graphics section and the disk controller request wait states as levels that are held for as long as they need. An access to video memory receives one inserted wait cycle when automatic waits are enabled. A request from the RS-422 path also receives one inserted cycle. All requests are merged into one wait output. A watchdog counter limits how long that output can stay low. The counter is driven by a prescaled tick. By default it allows 64 ticks of 2 MHz, which is 32 µs, and after that it releases the line until every request has gone away.

Top module: `sysctl_wait`

## Requirements
- R1: A write of D1:D0 to port BASE+0 acts on lamp 0 and lamp 1 (`led[0]`, `led[1]`). Value 2'b10 lights lamp 0 and value 2'b01 lights lamp 1; in both cases the other lamp keeps its state. Value 2'b11 turns both lamps off and value 2'b00 changes nothing. The new state appears on the clock edge after the write.
- R2: A write to port BASE+1 uses the encoding of R1 on lamps 2 and 3. Value 2'b10 acts on `led[2]` and value 2'b01 acts on `led[3]`.
- R3: A write to port BASE+2 sets `ser_en` to the inverse of D0 and `autowait_en` to the inverse of D1.
- R4: A write to port BASE+3 of 2'b00, 2'b01 or 2'b10 sets `bank` to that value. A write of 2'b11 leaves `bank` unchanged.
- R5: After the synchronous reset, all lamps are off, `bank` is 0, `ser_en` is 0, `autowait_en` is 1 and `wait_n` is 1.
- R6: While `autowait_en` is 1, a rising edge of `vid_acc` causes `wait_n` to be low for exactly one cycle, two clock edges after the edge at which the rise is sampled. While `autowait_en` is 0, a video access inserts no wait.
- R7: A rising edge of `ser_wait` causes exactly one low cycle of `wait_n`, with the same latency as in R6, regardless of how long the request is held.
- R8: `gfx_wait` and `dsk_wait` are OR-combined level requests. `wait_n` goes low on the edge after either of them is sampled high, and it returns high on the edge after all requests are gone.
- R9: `wait_n` stays low for at most TICK_DIV*LIMIT consecutive cycles under a continuous request. After that it is high until no request is pending.
- R10: When no request is pending, the timeout clears. The next request therefore gets the full TICK_DIV*LIMIT window again.
- R11: Writes to addresses outside BASE..BASE+3, and bus cycles without `io_wr`, leave all control outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O port address |
| io_data | input | 2 | Data bits D1:D0 |
| vid_acc | input | 1 | Video memory access in progress |
| gfx_wait | input | 1 | Graphics wait request (level) |
| dsk_wait | input | 1 | Disk controller wait request (level) |
| ser_wait | input | 1 | RS-422 wait request (edge gives one wait) |
| led | output | 4 | Diagnostic lamps, 1 means lit |
| ser_en | output | 1 | RS-422 channel enable |
| autowait_en | output | 1 | Automatic video wait enable |
| bank | output | 2 | Main memory bank select |
| wait_n | output | 1 | Processor wait, active low |

## Verification
The bench builds the block with TICK_DIV=4 and LIMIT=8. This shortens the wait timeout to 32 cycles, so long requests that expire, and fresh requests after the timeout has cleared, both fit into a short run. At these values a request held past the limit shows both the release of the wait line and the hold-off until the request drops. A behavioural model is compared with all outputs on every clock. It covers every port encoding, the ignored bank value, foreign addresses, and overlapping wait sources.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [1:0] {
    PORT_LAMP_A = 2'd0,
    PORT_LAMP_B = 2'd1,
    PORT_SERCFG = 2'd2,
    PORT_BANK   = 2'd3
  } port_sel_e;

  localparam logic [1:0] CODE_LO_ON  = 2'b10;
  localparam logic [1:0] CODE_HI_ON  = 2'b01;
  localparam logic [1:0] CODE_ALLOFF = 2'b11;
  localparam logic [1:0] BANK_BAD    = 2'b11;
endpackage

// File: rtl/ctl_port_regs.sv
module ctl_port_regs
  import sysctl_pkg::*;
#(
  parameter logic [7:0] BASE = 8'h10,
  parameter int LAMP_PAIRS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    io_wr,
  input  logic [7:0]              io_addr,
  input  logic [1:0]              io_data,
  output logic [2*LAMP_PAIRS-1:0] led,
  output logic                    ser_en,
  output logic                    autowait_en,
  output logic [1:0]              bank
);
  logic      hit;
  port_sel_e sel;

  assign hit = io_wr && (io_addr[7:2] == BASE[7:2]);
  assign sel = port_sel_e'(io_addr[1:0]);

  for (genvar g = 0; g < LAMP_PAIRS; g++) begin : g_lamp
    always_ff @(posedge clk) begin
      if (rst) begin
        led[2*g+1:2*g] <= 2'b00;
      end else if (hit && (sel == port_sel_e'(g))) begin
        unique case (io_data)
          CODE_LO_ON:  led[2*g]   <= 1'b1;
          CODE_HI_ON:  led[2*g+1] <= 1'b1;
          CODE_ALLOFF: led[2*g+1:2*g] <= 2'b00;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_en      <= 1'b0;
      autowait_en <= 1'b1;
      bank        <= 2'd0;
    end else if (hit) begin
      if (sel == PORT_SERCFG) begin
        ser_en      <= ~io_data[0];
        autowait_en <= ~io_data[1];
      end
      if (sel == PORT_BANK && io_data != BANK_BAD) begin
        bank <= io_data;
      end
    end
  end
endmodule

// File: rtl/edge_wait_cell.sv
module edge_wait_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic req_in,
  output logic pulse
);
  logic req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d <= 1'b0;
      pulse <= 1'b0;
    end else begin
      req_d <= req_in;
      pulse <= req_in && !req_d && en;
    end
  end
endmodule

// File: rtl/wait_timeout.sv
module wait_timeout #(
  parameter int TICK_DIV = 50,
  parameter int LIMIT    = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic wait_n
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [PRE_W-1:0] PRE_END = PRE_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LIMIT - 1);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] ticks;
  logic             expired;

  always_ff @(posedge clk) begin
    if (rst || !req) begin
      pre     <= '0;
      ticks   <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (pre == PRE_END) begin
        pre <= '0;
        if (ticks == CNT_END) expired <= 1'b1;
        else                  ticks   <= ticks + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wait_n <= 1'b1;
    else     wait_n <= ~(req && !expired);
  end
endmodule

// File: rtl/sysctl_wait.sv
module sysctl_wait #(
  parameter logic [7:0] BASE = 8'h10,
  parameter int TICK_DIV = 50,
  parameter int LIMIT    = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       io_wr,
  input  logic [7:0] io_addr,
  input  logic [1:0] io_data,
  input  logic       vid_acc,
  input  logic       gfx_wait,
  input  logic       dsk_wait,
  input  logic       ser_wait,
  output logic [3:0] led,
  output logic       ser_en,
  output logic       autowait_en,
  output logic [1:0] bank,
  output logic       wait_n
);
  localparam int NCELL = 2;

  logic [NCELL-1:0] cell_req, cell_en, cell_pulse;
  logic             any_req;

  ctl_port_regs #(.BASE(BASE), .LAMP_PAIRS(2)) u_regs (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
    .led(led), .ser_en(ser_en), .autowait_en(autowait_en), .bank(bank)
  );

  assign cell_req = {ser_wait, vid_acc};
  assign cell_en  = {1'b1, autowait_en};

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    edge_wait_cell u_cell (
      .clk(clk), .rst(rst), .en(cell_en[i]), .req_in(cell_req[i]),
      .pulse(cell_pulse[i])
    );
  end

  assign any_req = gfx_wait || dsk_wait || (|cell_pulse);

  wait_timeout #(.TICK_DIV(TICK_DIV), .LIMIT(LIMIT)) u_tmo (
    .clk(clk), .rst(rst), .req(any_req), .wait_n(wait_n)
  );
endmodule

// File: rtl/sysctl_wait_chk.sv
module sysctl_wait_chk #(
  parameter logic [7:0] BASE = 8'h10,
  parameter int TICK_DIV = 50,
  parameter int LIMIT    = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       io_wr,
  input logic [7:0] io_addr,
  input logic [1:0] io_data,
  input logic       vid_acc,
  input logic       gfx_wait,
  input logic       dsk_wait,
  input logic       ser_wait,
  input logic [3:0] led,
  input logic       ser_en,
  input logic       autowait_en,
  input logic [1:0] bank,
  input logic       wait_n
);
  localparam int TOTAL = TICK_DIV * LIMIT;
  int low_run;

  always_ff @(posedge clk) begin
    if (rst || wait_n) low_run <= 0;
    else if (low_run <= TOTAL) low_run <= low_run + 1;
  end

  // R1: all-off code clears lamps 0 and 1
  p_lamp_off_r1: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == BASE && io_data == 2'b11) |=> (led[1:0] == 2'b00));

  // R3: serial channel enable follows inverse of D0, autowait follows inverse of D1
  p_sercfg_r3: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == BASE + 8'd2) |=>
      (ser_en == !$past(io_data[0]) && autowait_en == !$past(io_data[1])));

  // R4: bank value 3 ignored
  p_bank_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == BASE + 8'd3 && io_data == 2'b11) |=> $stable(bank));

  // R8: with no source active, the wait line is released
  p_idle_release_r8: assert property (@(posedge clk) disable iff (rst)
    (!gfx_wait && !dsk_wait && $past(!vid_acc) && $past(!ser_wait)) |=> wait_n);

  // R9: wait never held longer than the timeout window
  p_wait_limit_r9: assert property (@(posedge clk) disable iff (rst)
    low_run <= TOTAL);
endmodule

bind sysctl_wait sysctl_wait_chk #(.BASE(BASE), .TICK_DIV(TICK_DIV), .LIMIT(LIMIT)) u_chk (.*);

// File: tb/tb_sysctl_wait.sv
`timescale 1ns/1ps
module tb_sysctl_wait;
  localparam int DIV = 4;
  localparam int LIM = 8;
  localparam int T   = DIV * LIM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic [1:0] io_data = 2'b00;
  logic vid_acc = 1'b0, gfx_wait = 1'b0, dsk_wait = 1'b0, ser_wait = 1'b0;
  logic [3:0] led;
  logic ser_en, autowait_en, wait_n;
  logic [1:0] bank;

  int checks = 0;
  int errors = 0;
  string tag = "R5";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sysctl_wait #(.BASE(8'h10), .TICK_DIV(DIV), .LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
    .vid_acc(vid_acc), .gfx_wait(gfx_wait), .dsk_wait(dsk_wait), .ser_wait(ser_wait),
    .led(led), .ser_en(ser_en), .autowait_en(autowait_en), .bank(bank), .wait_n(wait_n)
  );

  // behavioural reference model
  bit m_led[4];
  bit m_ser, m_aw, m_wait_n;
  int m_bank;
  bit vid_prev, ser_prev, aw_pend, ser_pend;
  int run;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_led[i]) m_led[i] = 0;
      m_ser = 0; m_aw = 1; m_wait_n = 1; m_bank = 0;
      vid_prev = 0; ser_prev = 0; aw_pend = 0; ser_pend = 0; run = 0;
    end else begin
      bit req;
      req = gfx_wait || dsk_wait || aw_pend || ser_pend;
      m_wait_n = !(req && run < T);
      if (req) begin if (run < T) run++; end
      else run = 0;
      aw_pend  = vid_acc && !vid_prev && m_aw;
      ser_pend = ser_wait && !ser_prev;
      vid_prev = vid_acc;
      ser_prev = ser_wait;
      if (io_wr) begin
        int d;
        d = io_data;
        case (io_addr)
          8'h10, 8'h11: begin
            int b;
            b = (io_addr == 8'h10) ? 0 : 2;
            if (d == 2) m_led[b] = 1;
            else if (d == 1) m_led[b+1] = 1;
            else if (d == 3) begin m_led[b] = 0; m_led[b+1] = 0; end
          end
          8'h12: begin m_ser = (d % 2) == 0; m_aw = d < 2; end
          8'h13: if (d != 3) m_bank = d;
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("led", led, {m_led[3], m_led[2], m_led[1], m_led[0]});
      cmp("ser_en", ser_en, m_ser);
      cmp("autowait_en", autowait_en, m_aw);
      cmp("bank", bank, m_bank);
      cmp("wait_n", wait_n, m_wait_n);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [1:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_data = d;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 8'h00; io_data = 2'b00;
  endtask

  task automatic bus_noise(logic [7:0] a, logic [1:0] d);
    @(negedge clk);
    io_wr = 1'b0; io_addr = a; io_data = d;
    @(negedge clk);
    io_addr = 8'h00; io_data = 2'b00;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tag = "R5";
    idle(3);
    @(negedge clk); rst = 1'b0;
    // explicit reset state check, R5
    cmp("reset led", led, 0);
    cmp("reset autowait_en", autowait_en, 1);
    cmp("reset wait_n", wait_n, 1);
    idle(2);

    tag = "R1";
    wr(8'h10, 2'b10); wr(8'h10, 2'b01); idle(1);
    cmp("lamps 0 and 1 lit", led[1:0], 3);
    wr(8'h10, 2'b00); wr(8'h10, 2'b11); idle(1);
    cmp("lamps 0 and 1 off", led[1:0], 0);

    tag = "R2";
    wr(8'h11, 2'b01); wr(8'h11, 2'b10); wr(8'h11, 2'b11); wr(8'h11, 2'b01); idle(1);
    cmp("lamp 3 only", led, 4'b1000);

    tag = "R3";
    for (int v = 0; v < 4; v++) begin
      wr(8'h12, 2'(v)); idle(1);
    end
    wr(8'h12, 2'b00); idle(1);

    tag = "R4";
    wr(8'h13, 2'b10); wr(8'h13, 2'b11); idle(1);
    cmp("bank after ignored write", bank, 2);
    wr(8'h13, 2'b01); wr(8'h13, 2'b00); idle(1);

    tag = "R11";
    wr(8'h14, 2'b11); wr(8'h0F, 2'b10); wr(8'h93, 2'b01);
    bus_noise(8'h10, 2'b10); bus_noise(8'h13, 2'b10); idle(2);

    tag = "R6";
    @(negedge clk) vid_acc = 1'b1; idle(4); vid_acc = 1'b0; idle(3);
    @(negedge clk) vid_acc = 1'b1; @(negedge clk) vid_acc = 1'b0; idle(4);
    wr(8'h12, 2'b10); idle(1);
    @(negedge clk) vid_acc = 1'b1; idle(4); vid_acc = 1'b0; idle(3);
    wr(8'h12, 2'b00); idle(1);

    tag = "R7";
    @(negedge clk) ser_wait = 1'b1; idle(6); ser_wait = 1'b0; idle(3);

    tag = "R8";
    @(negedge clk) gfx_wait = 1'b1; idle(5);
    dsk_wait = 1'b1; idle(3); gfx_wait = 1'b0; idle(3); dsk_wait = 1'b0; idle(3);
    @(negedge clk) dsk_wait = 1'b1; vid_acc = 1'b1; idle(4);
    dsk_wait = 1'b0; vid_acc = 1'b0; idle(3);

    tag = "R9";
    @(negedge clk) gfx_wait = 1'b1; idle(T + 10);
    @(negedge clk) ser_wait = 1'b1; idle(3); ser_wait = 1'b0; idle(3);
    gfx_wait = 1'b0; idle(3);

    tag = "R10";
    @(negedge clk) dsk_wait = 1'b1; idle(T - 4); dsk_wait = 1'b0; idle(2);
    @(negedge clk) dsk_wait = 1'b1; idle(T + 4); dsk_wait = 1'b0; idle(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule